// File: doc/BRIEF.md
# Endpoint-Zero Control Buffer Manager

This block looks after endpoint zero of a USB device. On one side it sits next to a packet engine. That engine has already decoded tokens and checked packets. It hands over one-cycle token strobes, a byte stream with a valid flag, and an end-of-packet strobe. It also reports when the host acknowledges an IN data packet. On the other side is a small CPU register bus with byte-wide reads and writes. Reads return data in the same cycle, and reading a data register pops a byte.

The block keeps three buffers: the eight-byte request carried by SETUP, a receive buffer for OUT data, and a transmit buffer for IN data. It tracks one flag per direction and uses these flags to answer each token with ACK or NAK. It raises a request interrupt when a complete SETUP packet arrives. A sticky protection flag tells firmware that the request it is working on has been replaced by a newer one. The CPU then clears that flag and reads the buffer again from the start.

Top module: `ep0_ctrl_buf`

## Requirements
- R1: A SETUP token empties both data buffers, clears the receive-full flag (STAT bit 2), the transmit-ready flag (STAT bit 3) and the receive length (RXLEN, address 4). The data packet that follows is always answered with hsValid=1, hsNak=0 one cycle after rxEop. If that packet held exactly 8 bytes, setupIrq (STAT bit 0) is set.
- R2: A SETUP token that arrives after a complete request has been received, and before the CPU writes 1 to CTRL (address 6) bit 2, sets the protection flag (STAT bit 1). A SETUP token that arrives after that write leaves the flag at 0.
- R3: Writing ICLR (address 1) with bit 1 = 0 clears the protection flag, and writing it with bit 0 = 0 clears setupIrq. Writing a 1 to either bit leaves that flag unchanged.
- R4: Successive reads of SETUP (address 2) return request bytes 0 to 7 in order. The read position restarts at byte 0 when a request completes and when the protection flag is cleared, so the next read always starts with the newest request.
- R5: An IN token is answered one cycle later with hsValid=1. hsNak=1 while transmit-ready is 0, and hsNak=0 (data is sent) while it is 1.
- R6: Writes to TXDATA (address 5) append bytes to the transmit buffer, and txLen shows how many bytes it holds. Writing 1 to CTRL bit 0 sets transmit-ready.
- R7: During an accepted IN transaction, txPop steps txData through the buffered bytes. hostAck clears transmit-ready and empties the buffer. A repeated IN token without hostAck restarts the data at byte 0.
- R8: An OUT packet is answered one cycle after rxEop. It is NAKed (hsNak=1) while receive-full is 1, and its bytes are then discarded and RXLEN is unchanged. Otherwise it is ACKed: up to 64 bytes are stored, RXLEN gives the stored count, and receive-full is set when that count is non-zero.
- R9: Reads of RXDATA (address 3) return the stored OUT bytes in order. Receive-full stays at 1 until the last stored byte has been read, and drops to 0 right after that read.
- R10: Writing 1 to CTRL bit 1 empties the receive buffer and clears receive-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tokSetup | input | 1 | SETUP token strobe |
| tokIn | input | 1 | IN token strobe |
| tokOut | input | 1 | OUT token strobe |
| rxValid | input | 1 | Data byte valid from the packet engine |
| rxData | input | 8 | Received data byte |
| rxEop | input | 1 | End of a good data packet |
| txPop | input | 1 | Packet engine takes the current transmit byte |
| hostAck | input | 1 | Host acknowledged the IN data packet |
| hsValid | output | 1 | Handshake decision valid |
| hsNak | output | 1 | 1 = NAK, 0 = ACK or send data |
| txData | output | 8 | Current transmit byte |
| txLen | output | 7 | Bytes held in the transmit buffer |
| cpuWe | input | 1 | CPU register write |
| cpuRe | input | 1 | CPU register read (pops data registers) |
| cpuAddr | input | 3 | CPU register address |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | CPU read data, valid in the same cycle |
| setupIrq | output | 1 | Request-received interrupt |

## Verification
The hardest situation to reach is a new request landing while firmware is partway through reading the old one. From the ports, that means a complete SETUP, then a few SETUP reads, then a second SETUP with no end-of-transfer write in between, then more reads before the protection flag is cleared. The directed sequence builds exactly that chain. It then checks that a clear attempt with the bit held at 1 changes nothing, and that the real clear restarts reading at the newest request's first byte. The random OUT traffic drives the receive flag through ACKed, NAKed, zero-length, over-long, drained and flushed packets. A bench model predicts each handshake and length.

// File: rtl/ep0_pkg.sv
package ep0_pkg;

  localparam logic [2:0] ADDR_STAT   = 3'd0;
  localparam logic [2:0] ADDR_ICLR   = 3'd1;
  localparam logic [2:0] ADDR_SETUP  = 3'd2;
  localparam logic [2:0] ADDR_RXDATA = 3'd3;
  localparam logic [2:0] ADDR_RXLEN  = 3'd4;
  localparam logic [2:0] ADDR_TXDATA = 3'd5;
  localparam logic [2:0] ADDR_CTRL   = 3'd6;

  // Bit positions in ICLR and CTRL
  localparam int ICLR_IRQ   = 0;
  localparam int ICLR_PROT  = 1;
  localparam int CTRL_TXRDY = 0;
  localparam int CTRL_RXCLR = 1;
  localparam int CTRL_XEND  = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_OUT,
    PH_DROP,
    PH_INWAIT
  } phase_e;

  typedef struct packed {
    logic setupFlush;
    logic setupPush;
    logic setupRewind;
    logic setupPop;
    logic rxFlush;
    logic rxPush;
    logic rxPop;
    logic txFlush;
    logic txPush;
    logic txPop;
    logic txRewind;
  } dpStrobe_t;

endpackage

// File: rtl/ep0_lbuf.sv
// Linear byte buffer: fill from zero, read forward, rewind or flush as a whole.
module ep0_lbuf #(
  parameter int DEPTH      = 64,
  parameter int CNT_W      = $clog2(DEPTH + 1),
  parameter bit COUNT_FILL = 1'b1  // 1: count = bytes written, 0: count = bytes unread
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             rewind,
  input  logic             push,
  input  logic             pop,
  input  logic [7:0]       din,
  output logic [7:0]       head,
  output logic [CNT_W-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] wrPtr;
  logic [CNT_W-1:0] rdPtr;
  logic             canPush;

  assign canPush = push && (wrPtr < CNT_W'(DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (canPush) wrPtr <= wrPtr + 1'b1;
      if (rewind) rdPtr <= '0;
      else if (pop && (rdPtr < wrPtr)) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (canPush && !flush) mem[wrPtr[AW-1:0]] <= din;
  end

  assign head = mem[rdPtr[AW-1:0]];

  generate
    if (COUNT_FILL) begin : g_fill
      assign count = wrPtr;
    end else begin : g_level
      assign count = wrPtr - rdPtr;
    end
  endgenerate

endmodule

// File: rtl/ep0_dp.sv
// Datapath: request buffer, receive buffer, transmit buffer.
module ep0_dp
  import ep0_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int SETUP_LEN  = 8,
  parameter int LEN_W      = $clog2(FIFO_DEPTH + 1),
  parameter int SCNT_W     = $clog2(SETUP_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [7:0]        rxData,
  input  logic [7:0]        cpuWdata,
  output logic [7:0]        setupByte,
  output logic [SCNT_W-1:0] setupCnt,
  output logic [7:0]        rxHead,
  output logic [LEN_W-1:0]  rxLevel,
  output logic [7:0]        txHead,
  output logic [LEN_W-1:0]  txLen
);

  ep0_lbuf #(.DEPTH(SETUP_LEN), .CNT_W(SCNT_W), .COUNT_FILL(1'b1)) u_setupBuf (
    .clk    (clk),
    .rstN   (rstN),
    .flush  (st.setupFlush),
    .rewind (st.setupRewind),
    .push   (st.setupPush),
    .pop    (st.setupPop),
    .din    (rxData),
    .head   (setupByte),
    .count  (setupCnt)
  );

  ep0_lbuf #(.DEPTH(FIFO_DEPTH), .CNT_W(LEN_W), .COUNT_FILL(1'b0)) u_rxBuf (
    .clk    (clk),
    .rstN   (rstN),
    .flush  (st.rxFlush),
    .rewind (1'b0),
    .push   (st.rxPush),
    .pop    (st.rxPop),
    .din    (rxData),
    .head   (rxHead),
    .count  (rxLevel)
  );

  ep0_lbuf #(.DEPTH(FIFO_DEPTH), .CNT_W(LEN_W), .COUNT_FILL(1'b1)) u_txBuf (
    .clk    (clk),
    .rstN   (rstN),
    .flush  (st.txFlush),
    .rewind (st.txRewind),
    .push   (st.txPush),
    .pop    (st.txPop),
    .din    (cpuWdata),
    .head   (txHead),
    .count  (txLen)
  );

endmodule

// File: rtl/ep0_ctl.sv
// Control: transaction phase, direction flags, handshakes, register decode.
module ep0_ctl
  import ep0_pkg::*;
#(
  parameter int SETUP_LEN = 8,
  parameter int LEN_W     = 7,
  parameter int SCNT_W    = $clog2(SETUP_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokSetup,
  input  logic              tokIn,
  input  logic              tokOut,
  input  logic              rxValid,
  input  logic              rxEop,
  input  logic              txPop,
  input  logic              hostAck,
  input  logic              cpuWe,
  input  logic              cpuRe,
  input  logic [2:0]        cpuAddr,
  input  logic [7:0]        cpuWdata,
  input  logic [SCNT_W-1:0] setupCnt,
  input  logic [LEN_W-1:0]  rxLevel,
  input  logic [7:0]        setupByte,
  input  logic [7:0]        rxHead,
  output dpStrobe_t         st,
  output logic              hsValid,
  output logic              hsNak,
  output logic              setupIrq,
  output logic              prot,
  output logic              rxFull,
  output logic              txReady,
  output logic [7:0]        cpuRdata
);

  phase_e           phase;
  logic             ctrlActive;
  logic [LEN_W-1:0] rxLen;

  logic wrIclr, wrCtrl, wrTx, rdSetup, rdRx;
  logic dataEop, setupDone, setupGood, outDone, inAck;

  assign wrIclr  = cpuWe && (cpuAddr == ADDR_ICLR);
  assign wrCtrl  = cpuWe && (cpuAddr == ADDR_CTRL);
  assign wrTx    = cpuWe && (cpuAddr == ADDR_TXDATA);
  assign rdSetup = cpuRe && (cpuAddr == ADDR_SETUP);
  assign rdRx    = cpuRe && (cpuAddr == ADDR_RXDATA) && rxFull;

  assign dataEop   = rxEop && (phase == PH_SETUP || phase == PH_OUT || phase == PH_DROP);
  assign setupDone = rxEop && (phase == PH_SETUP);
  assign setupGood = setupDone && (setupCnt == SCNT_W'(SETUP_LEN));
  assign outDone   = rxEop && (phase == PH_OUT);
  assign inAck     = hostAck && (phase == PH_INWAIT);

  always_comb begin
    st             = '0;
    st.setupFlush  = tokSetup;
    st.setupPush   = rxValid && (phase == PH_SETUP);
    st.setupRewind = setupDone || (wrIclr && !cpuWdata[ICLR_PROT]);
    st.setupPop    = rdSetup;
    st.rxFlush     = tokSetup || (wrCtrl && cpuWdata[CTRL_RXCLR]) || (tokOut && !rxFull);
    st.rxPush      = rxValid && (phase == PH_OUT);
    st.rxPop       = rdRx;
    st.txFlush     = tokSetup || inAck;
    st.txPush      = wrTx;
    st.txPop       = txPop && (phase == PH_INWAIT);
    st.txRewind    = tokIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      ctrlActive <= 1'b0;
      setupIrq   <= 1'b0;
      prot       <= 1'b0;
      rxFull     <= 1'b0;
      txReady    <= 1'b0;
      rxLen      <= '0;
      hsValid    <= 1'b0;
      hsNak      <= 1'b0;
    end else begin
      // transaction phase
      if (tokSetup)                phase <= PH_SETUP;
      else if (tokOut)             phase <= rxFull ? PH_DROP : PH_OUT;
      else if (tokIn)              phase <= txReady ? PH_INWAIT : PH_IDLE;
      else if (dataEop || inAck)   phase <= PH_IDLE;

      // handshake decision
      hsValid <= tokIn || dataEop;
      hsNak   <= tokIn ? !txReady : (dataEop && (phase == PH_DROP));

      // request tracking
      if (setupGood)                                  ctrlActive <= 1'b1;
      else if (wrCtrl && cpuWdata[CTRL_XEND])         ctrlActive <= 1'b0;

      if (setupGood)                                  setupIrq <= 1'b1;
      else if (wrIclr && !cpuWdata[ICLR_IRQ])         setupIrq <= 1'b0;

      if (tokSetup && ctrlActive)                     prot <= 1'b1;
      else if (wrIclr && !cpuWdata[ICLR_PROT])        prot <= 1'b0;

      // receive side
      if (tokSetup)                                   rxFull <= 1'b0;
      else if (wrCtrl && cpuWdata[CTRL_RXCLR])        rxFull <= 1'b0;
      else if (outDone && (rxLevel != '0))            rxFull <= 1'b1;
      else if (rdRx && (rxLevel == LEN_W'(1)))        rxFull <= 1'b0;

      if (tokSetup)                                   rxLen <= '0;
      else if (outDone)                               rxLen <= rxLevel;

      // transmit side
      if (tokSetup || inAck)                          txReady <= 1'b0;
      else if (wrCtrl && cpuWdata[CTRL_TXRDY])        txReady <= 1'b1;
    end
  end

  always_comb begin
    case (cpuAddr)
      ADDR_STAT:   cpuRdata = {4'b0, txReady, rxFull, prot, setupIrq};
      ADDR_SETUP:  cpuRdata = setupByte;
      ADDR_RXDATA: cpuRdata = rxHead;
      ADDR_RXLEN:  cpuRdata = 8'(rxLen);
      default:     cpuRdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/ep0_ctrl_buf.sv
// Endpoint-zero control buffer manager, top level.
module ep0_ctrl_buf
  import ep0_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int SETUP_LEN  = 8,
  parameter int LEN_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tokSetup,
  input  logic             tokIn,
  input  logic             tokOut,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic             rxEop,
  input  logic             txPop,
  input  logic             hostAck,
  output logic             hsValid,
  output logic             hsNak,
  output logic [7:0]       txData,
  output logic [LEN_W-1:0] txLen,
  input  logic             cpuWe,
  input  logic             cpuRe,
  input  logic [2:0]       cpuAddr,
  input  logic [7:0]       cpuWdata,
  output logic [7:0]       cpuRdata,
  output logic             setupIrq
);
  localparam int SCNT_W = $clog2(SETUP_LEN + 1);

  dpStrobe_t         st;
  logic [7:0]        setupByte;
  logic [SCNT_W-1:0] setupCnt;
  logic [7:0]        rxHead;
  logic [LEN_W-1:0]  rxLevel;
  logic              prot;
  logic              rxFull;
  logic              txReady;

  ep0_ctl #(.SETUP_LEN(SETUP_LEN), .LEN_W(LEN_W), .SCNT_W(SCNT_W)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .tokSetup  (tokSetup),
    .tokIn     (tokIn),
    .tokOut    (tokOut),
    .rxValid   (rxValid),
    .rxEop     (rxEop),
    .txPop     (txPop),
    .hostAck   (hostAck),
    .cpuWe     (cpuWe),
    .cpuRe     (cpuRe),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .setupCnt  (setupCnt),
    .rxLevel   (rxLevel),
    .setupByte (setupByte),
    .rxHead    (rxHead),
    .st        (st),
    .hsValid   (hsValid),
    .hsNak     (hsNak),
    .setupIrq  (setupIrq),
    .prot      (prot),
    .rxFull    (rxFull),
    .txReady   (txReady),
    .cpuRdata  (cpuRdata)
  );

  ep0_dp #(.FIFO_DEPTH(FIFO_DEPTH), .SETUP_LEN(SETUP_LEN), .LEN_W(LEN_W), .SCNT_W(SCNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .rxData    (rxData),
    .cpuWdata  (cpuWdata),
    .setupByte (setupByte),
    .setupCnt  (setupCnt),
    .rxHead    (rxHead),
    .rxLevel   (rxLevel),
    .txHead    (txData),
    .txLen     (txLen)
  );

endmodule

// File: rtl/ep0_ctrl_buf_chk.sv
module ep0_ctrl_buf_chk
  import ep0_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             tokSetup,
  input logic             tokIn,
  input logic             hsValid,
  input logic             hsNak,
  input logic             txReady,
  input logic             rxFull,
  input logic             prot,
  input logic             cpuWe,
  input logic [2:0]       cpuAddr,
  input logic [7:0]       cpuWdata,
  input logic [LEN_W-1:0] txLen,
  input logic [LEN_W-1:0] rxLevel
);

  AST_SETUP_RESETS_BUFS: assert property (@(posedge clk) disable iff (!rstN)
    tokSetup |=> (!txReady && !rxFull && txLen == '0 && rxLevel == '0)); // R1

  AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (prot && !(cpuWe && cpuAddr == ADDR_ICLR && !cpuWdata[ICLR_PROT])) |=> prot); // R3

  AST_IN_NAK_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (tokIn && !txReady) |=> (hsValid && hsNak)); // R5

  AST_IN_DATA_READY: assert property (@(posedge clk) disable iff (!rstN)
    (tokIn && txReady) |=> (hsValid && !hsNak)); // R5

  AST_RXFULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !tokSetup && !(cpuWe && cpuAddr == ADDR_CTRL && cpuWdata[CTRL_RXCLR])
     && rxLevel > LEN_W'(1)) |=> rxFull); // R9

endmodule

bind ep0_ctrl_buf ep0_ctrl_buf_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/ep0_ctrl_buf_tb.sv
`timescale 1ns/1ps
module ep0_ctrl_buf_tb;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tokSetup = 0, tokIn = 0, tokOut = 0, rxValid = 0, rxEop = 0, txPop = 0, hostAck = 0;
  logic [7:0] rxData = 0;
  logic       hsValid, hsNak, setupIrq;
  logic [7:0] txData;
  logic [6:0] txLen;
  logic       cpuWe = 0, cpuRe = 0;
  logic [2:0] cpuAddr = 0;
  logic [7:0] cpuWdata = 0;
  logic [7:0] cpuRdata;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] pkt  [72];
  logic [7:0] refB [72];

  always #2 clk = ~clk;

  ep0_ctrl_buf u_dut (
    .clk(clk), .rstN(rstN), .tokSetup(tokSetup), .tokIn(tokIn), .tokOut(tokOut),
    .rxValid(rxValid), .rxData(rxData), .rxEop(rxEop), .txPop(txPop), .hostAck(hostAck),
    .hsValid(hsValid), .hsNak(hsNak), .txData(txData), .txLen(txLen),
    .cpuWe(cpuWe), .cpuRe(cpuRe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .setupIrq(setupIrq)
  );

  function automatic int storedLen(int n);
    return (n > DEPTH) ? DEPTH : n;
  endfunction

  function automatic logic [7:0] setupPattern(int seed, int i);
    return 8'((seed * 37 + i * 11 + 5) & 8'hFF);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cpuWrite(logic [2:0] a, logic [7:0] d);
    cpuWe = 1; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    cpuWe = 0;
  endtask

  task automatic cpuRead(logic [2:0] a, output logic [7:0] d);
    cpuRe = 1; cpuAddr = a;
    #1 d = cpuRdata;
    @(negedge clk);
    cpuRe = 0;
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] d);
    cpuAddr = a;
    #1 d = cpuRdata;
    @(negedge clk);
  endtask

  // isSetup=1 sends SETUP, else OUT; n bytes from pkt
  task automatic sendPkt(bit isSetup, int n, output logic hv, output logic hn);
    if (isSetup) tokSetup = 1; else tokOut = 1;
    @(negedge clk);
    tokSetup = 0; tokOut = 0;
    for (int i = 0; i < n; i++) begin
      rxValid = 1; rxData = pkt[i];
      @(negedge clk);
    end
    rxValid = 0; rxEop = 1;
    @(negedge clk);
    rxEop = 0;
    hv = hsValid; hn = hsNak;
  endtask

  task automatic sendIn(output logic hv, output logic hn);
    tokIn = 1;
    @(negedge clk);
    tokIn = 0;
    hv = hsValid; hn = hsNak;
  endtask

  task automatic loadSetup(int seed);
    for (int i = 0; i < 8; i++) pkt[i] = setupPattern(seed, i);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic hv, hn;
    bit expFull;
    int expLen;
    void'($urandom(32'd24681));

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // reset state
    peek(3'd0, d); check("R1 reset status", d, 0);
    check("R6 reset txLen", txLen, 0);
    check("R5 reset hsValid", hsValid, 0);

    // SETUP A
    loadSetup(1);
    sendPkt(1, 8, hv, hn);
    check("R1 setup hsValid", hv, 1);
    check("R1 setup ack", hn, 0);
    check("R1 setupIrq", setupIrq, 1);
    for (int i = 0; i < 8; i++) begin
      cpuRead(3'd2, d); check("R4 setup byte", d, setupPattern(1, i));
    end
    cpuWrite(3'd1, 8'hFF); check("R3 irq kept on 1", setupIrq, 1);
    cpuWrite(3'd1, 8'hFE); check("R3 irq cleared", setupIrq, 0);

    // IN before ready
    sendIn(hv, hn);
    check("R5 nak valid", hv, 1); check("R5 nak not ready", hn, 1);

    // load tx
    for (int i = 0; i < 5; i++) cpuWrite(3'd5, 8'(8'hA0 + i));
    check("R6 txLen", txLen, 5);
    cpuWrite(3'd6, 8'h01);
    peek(3'd0, d); check("R6 txReady set", d[3], 1);
    sendIn(hv, hn);
    check("R5 data valid", hv, 1); check("R5 data sent", hn, 0);
    for (int i = 0; i < 3; i++) begin
      txPop = 1; #1 check("R7 tx byte", txData, 8'hA0 + i);
      @(negedge clk);
    end
    txPop = 0;
    sendIn(hv, hn);
    check("R7 retry ack", hn, 0);
    for (int i = 0; i < 5; i++) begin
      txPop = 1; #1 check("R7 retry byte", txData, 8'hA0 + i);
      @(negedge clk);
    end
    txPop = 0; hostAck = 1;
    @(negedge clk);
    hostAck = 0;
    peek(3'd0, d); check("R7 txReady cleared", d[3], 0);
    check("R7 tx emptied", txLen, 0);

    // random OUT traffic
    expFull = 0; expLen = 0;
    for (int it = 0; it < 30; it++) begin
      int n;
      int act;
      n = $urandom_range(0, 70);
      if (it == 3) n = 70;
      if (it == 4) n = 0;
      for (int i = 0; i < n; i++) pkt[i] = 8'($urandom_range(0, 255));
      sendPkt(0, n, hv, hn);
      check("R8 out valid", hv, 1);
      check("R8 out handshake", hn, expFull);
      if (!expFull) begin
        expLen = storedLen(n);
        expFull = (expLen > 0);
        for (int i = 0; i < expLen; i++) refB[i] = pkt[i];
      end
      peek(3'd4, d); check("R8 rx length", d, expLen);
      peek(3'd0, d); check("R8 rx full", d[2], expFull);
      act = $urandom_range(0, 2);
      if (expFull && act == 0) begin
        for (int i = 0; i < expLen; i++) begin
          if (i == expLen - 1 && expLen > 1) begin
            peek(3'd0, d); check("R9 full before last", d[2], 1);
          end
          cpuRead(3'd3, d); check("R9 rx byte", d, refB[i]);
        end
        peek(3'd0, d); check("R9 drained", d[2], 0);
        expFull = 0;
      end else if (expFull && act == 1) begin
        cpuWrite(3'd6, 8'h02);
        peek(3'd0, d); check("R10 rx cleared", d[2], 0);
        expFull = 0;
      end
    end
    if (expFull) cpuWrite(3'd6, 8'h02);

    // protection: transfer ended, then new request -> no prot
    cpuWrite(3'd6, 8'h04);
    loadSetup(2);
    sendPkt(1, 8, hv, hn);
    peek(3'd0, d); check("R2 no prot after end", d[1], 0);
    for (int i = 0; i < 3; i++) cpuRead(3'd2, d);
    loadSetup(3);
    sendPkt(1, 8, hv, hn);
    check("R1 setup ack during transfer", hn, 0);
    peek(3'd0, d); check("R2 prot set", d[1], 1);
    cpuRead(3'd2, d); check("R4 newest first byte", d, setupPattern(3, 0));
    cpuRead(3'd2, d);
    cpuWrite(3'd1, 8'hFF);
    peek(3'd0, d); check("R3 prot kept on 1", d[1], 1);
    cpuWrite(3'd1, 8'hFD);
    peek(3'd0, d); check("R3 prot cleared", d[1], 0);
    for (int i = 0; i < 8; i++) begin
      cpuRead(3'd2, d); check("R4 reread newest", d, setupPattern(3, i));
    end

    // SETUP clears both directions
    for (int i = 0; i < 3; i++) cpuWrite(3'd5, 8'(i));
    cpuWrite(3'd6, 8'h01);
    for (int i = 0; i < 4; i++) pkt[i] = 8'(i + 9);
    sendPkt(0, 4, hv, hn);
    peek(3'd0, d); check("R8 rx full pre setup", d[2], 1);
    loadSetup(4);
    sendPkt(1, 8, hv, hn);
    peek(3'd0, d); check("R1 rxFull cleared", d[2], 0);
    check("R1 txReady cleared", d[3], 0);
    check("R1 tx emptied", txLen, 0);
    peek(3'd4, d); check("R1 rx length cleared", d, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule